// File: doc/BRIEF.md
# Sequential Binary Fraction to Decimal Converter

This block takes an unsigned binary fraction of 19 bits, all of them below the binary point, and turns it into six decimal fraction digits packed as BCD. It handles one bit per clock with a single bank of per-digit correctors. A combinational converter would need one bank of correctors for every input bit, so this block is much smaller. The price is that a conversion occupies the block for 19 clock cycles. It is meant for display paths, where values change slowly compared with the clock.

The method runs double dabble in reverse. The input word is taken starting at its least significant bit. Each step shifts the BCD register one place to the right, and the current input bit drops into the register's top bit. After the shift, every 4-bit digit that holds a value above 7 is reduced by 3. After the last step, the lowest BCD bit is forced equal to the least significant input bit, because the shifting loses the parity of the last digit.

The host raises `start` for one cycle while `busy` is low. It then waits for the single-cycle `done` pulse and reads `bcd_out`.

Top module: `frac_bcd_serial`

## Requirements
- R1: After a conversion, `bcd_out` holds six BCD digits, each in the range 0 to 9. Bits [23:20] hold the tenths digit and bits [3:0] hold the millionths digit. Together they equal the value v, computed as follows: v starts at 0; for each input bit b, taken in order from bit 0 up to bit 18, v becomes floor((v + b*1000000)/2); finally, the lowest bit of v is replaced by input bit 0.
- R2: An input with only bits 18 and 17 set (binary 0.11) gives the digits 750000.
- R3: Input 19'b1011110100000000111 gives the digits 738295, and input 19'b1101011011011011110 gives the digits 839290.
- R4: Bit 0 of the final `bcd_out` equals bit 0 of the captured input.
- R5: `done` is high for exactly one cycle. It rises on the 19th rising edge after the edge that accepted `start`.
- R6: `busy` rises on the edge that accepts `start` and falls on the edge that raises `done`. `busy` and `done` are never high together.
- R7: A `start` that arrives while `busy` is high is ignored. The running conversion continues, its result is unchanged, and no extra `done` pulse appears.
- R8: While idle and with no `start`, `bcd_out` keeps the last result.
- R9: During reset, `busy` and `done` are low and `bcd_out` is zero.
- R10: On the cycle after a `start` is accepted, `bcd_out` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion. Accepted only when the block is idle |
| frac_in | input | 19 | Binary fraction, where bit 18 is worth one half |
| busy | output | 1 | A conversion is in progress |
| done | output | 1 | Single-cycle pulse: the result is ready |
| bcd_out | output | 24 | Six BCD digits, most significant digit in the top nibble |

## Verification
The hardest case to reach from the ports is a second `start` that lands partway through a conversion. It must leave both the running result and the pulse count untouched.

The stimulus handles this in three steps. It launches one conversion and waits a few cycles. It then drives `start` with a different fraction, which is never recorded in the scoreboard. Finally, it keeps the monitor watching long after the queue empties, so that any stray `done` pulse or corrupted result is caught as a miscompare.

Back-to-back conversions with an odd least significant bit exercise the parity restore at the moment the register is about to be reused.

// File: rtl/frac_bcd_serial.sv
module frac_bcd_serial #(
  parameter int FRAC_W = 19,
  parameter int DIGITS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAC_W-1:0]     frac_in,
  output logic                  busy,
  output logic                  done,
  output logic [4*DIGITS-1:0]   bcd_out
);
  localparam int BCD_W = 4 * DIGITS;
  localparam int CNT_W = $clog2(FRAC_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAC_W - 1);

  logic [FRAC_W-1:0] bin_q;
  logic [BCD_W-1:0]  bcd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              lsb_q;
  logic              busy_q;
  logic              done_q;

  logic [BCD_W-1:0]  shifted;
  logic [BCD_W-1:0]  fixed;
  logic              accept;
  logic              last_step;

  assign shifted   = {bin_q[0], bcd_q[BCD_W-1:1]};
  assign accept    = start && !busy_q;
  assign last_step = busy_q && (cnt_q == LAST);

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] d;
    assign d = shifted[4*g +: 4];
    assign fixed[4*g +: 4] = (d > 4'd7) ? d - 4'd3 : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      bcd_q  <= '0;
      cnt_q  <= '0;
      lsb_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        bin_q  <= frac_in;
        lsb_q  <= frac_in[0];
        bcd_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        bin_q <= {1'b0, bin_q[FRAC_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
        if (last_step) begin
          bcd_q  <= {fixed[BCD_W-1:1], lsb_q};
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bcd_q <= fixed;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign bcd_out = bcd_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_step) |=> busy && !done); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(bcd_out)); // R8
  AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy && bcd_out == '0); // R10
  AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bcd_out[0] == lsb_q); // R4

  for (genvar k = 0; k < DIGITS; k++) begin : g_chk
    AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> bcd_out[4*k +: 4] <= 4'd9); // R1
  end
endmodule

// File: tb/sim_frac_bcd_serial.sv
module sim_frac_bcd_serial;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [18:0] frac_in = '0;
  logic        busy, done;
  logic [23:0] bcd_out;

  frac_bcd_serial u0 (.clk(clk), .rst_n(rst_n), .start(start), .frac_in(frac_in),
                      .busy(busy), .done(done), .bcd_out(bcd_out));

  always #2 clk = ~clk;

  typedef struct { logic [23:0] val; int t; string tag; } item_t;
  item_t q[$];
  int cyc = 0, nvec = 0, nbad = 0;
  logic [23:0] last_res = '0;
  bit ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [23:0] model(input logic [18:0] x);
    longint v = 0;
    logic [23:0] r;
    for (int i = 0; i < 19; i++) v = (v + (x[i] ? 1000000 : 0)) / 2;
    v = (v & ~longint'(1)) | longint'(x[0]);
    for (int d = 0; d < 6; d++) begin
      r[4*d +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !ended) begin
    if (done) begin
      chk(!busy, "R6", 32'(busy), 32'd0);
      if (q.size() == 0) chk(1'b0, "R7 stray done", 32'(bcd_out), 32'hFFFFFFFF);
      else begin
        item_t it;
        it = q.pop_front();
        chk(bcd_out == it.val, it.tag, 32'(bcd_out), 32'(it.val));
        chk(cyc - it.t == 19, "R5 latency", 32'(cyc - it.t), 32'd19);
        last_res = bcd_out;
      end
    end
  end

  task automatic convert(input logic [18:0] x, input logic [23:0] exp, input string tag, input bit chk_clr);
    while (busy) @(negedge clk);
    start = 1'b1;
    frac_in = x;
    q.push_back('{val: exp, t: cyc + 1, tag: tag});
    @(negedge clk);
    start = 1'b0;
    if (chk_clr) begin
      chk(busy, "R10 busy", 32'(busy), 32'd1);
      chk(bcd_out == 24'd0, "R10 clear", 32'(bcd_out), 32'd0);
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1;
    chk(!busy && !done && bcd_out == 0, "R9 reset", 32'({busy, done}), 32'd0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && bcd_out == 0, "R9 reset held", 32'(bcd_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    convert(19'b1100000000000000000, 24'h750000, "R2 0.11", 1'b1);
    convert(19'b1011110100000000111, 24'h738295, "R3 738295", 1'b0);
    convert(19'b1101011011011011110, 24'h839290, "R3 839290", 1'b1);
    convert(19'd0, model(19'd0), "R1 zero", 1'b0);
    convert(19'h7FFFF, model(19'h7FFFF), "R1 all ones", 1'b0);
    convert(19'd1, model(19'd1), "R4 lsb only", 1'b0);
    for (int i = 0; i < 12; i++) begin
      logic [18:0] x;
      x = 19'((i * 40503 + 12345) ^ (i << 11));
      convert(x, model(x), "R1 pattern", 1'b0);
    end
    drain();
    chk(last_res[0] == model(19'((11 * 40503 + 12345) ^ (11 << 11)))[0], "R4 parity", 32'(last_res[0]), 32'd0);

    repeat (10) @(negedge clk);
    chk(bcd_out == last_res, "R8 hold", 32'(bcd_out), 32'(last_res));

    convert(19'h2AAAB, model(19'h2AAAB), "R7 first", 1'b0);
    repeat (5) @(negedge clk);
    start = 1'b1;
    frac_in = 19'h55555;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R7 still busy", 32'(busy), 32'd1);
    drain();
    repeat (30) @(negedge clk);
    chk(!busy && q.size() == 0, "R7 no restart", 32'(busy), 32'd0);
    chk(bcd_out == model(19'h2AAAB), "R7 result kept", 32'(bcd_out), 32'(model(19'h2AAAB)));

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!ended) begin
      ended = 1;
      nvec++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule